// File: doc/BRIEF.md
# Shared Divider Subroutine Call Engine

This block runs a fixed three-call program in hardware, in which every call site uses a single iterative unsigned divider instead of a private copy of it. A caller state machine and the divider state machine run side by side and are clocked every cycle. A call works as follows. In one state the caller writes the argument registers and raises the divider's call strobe. The divider treats that strobe as a restart and goes back to its entry state. The caller then spins in a wait state for that call site until the divider raises its one-cycle finish pulse. While it waits, the caller copies the divider's return value on every cycle, so the value it keeps is the one that came with finish.

The program computes `q0 = a / b`, then `r1 = a % c`, then `q2 = (q0 + r1) / c`, and returns `q2 + q0`. All arithmetic is modulo 2^W. Outside logic uses the same protocol. Holding `rst` high restarts the program and clears `done`. `op_a`, `op_b` and `op_c` are captured on the first clock edge after `rst` falls. When the program ends, `done` pulses for one cycle and `result` holds the answer. The outputs are plain control and data pins with no back-pressure. `done` is a one-shot pulse, and `result` holds its value until the next reset, so a consumer can read it whenever it likes.

Top module: `callshare_top`

## Requirements
- R1: While `rst` is high, `done` is low. After `rst` falls, `done` stays low until the program completes.
- R2: The divider returns the unsigned quotient when the mode argument is 0. `result` equals div(div(a,b) + mod(a,c), c) + div(a,b), with all values W bits wide and wrapping.
- R3: When the mode argument is 1, the divider returns the unsigned remainder. The second call site uses this mode.
- R4: Dividing by zero returns all ones as the quotient and the dividend as the remainder.
- R5: `done` is high for exactly one cycle. It is high in the cycle that follows rising edge number 3W+15 after `rst` falls, because each call costs W+4 cycles.
- R6: The call strobe lasts one cycle and is raised on the same edge that writes the arguments. The arguments stay stable while the divider iterates. A strobe sends the divider to its entry state with finish low.
- R7: Only one call is ever outstanding. No strobe is raised while the divider is loading, iterating or finishing.
- R8: The divider's finish pulse lasts one cycle. After it, the divider idles until the next strobe.
- R9: The caller leaves a wait state only on the edge after finish was high. The value it keeps is the return value seen with finish.
- R10: After `done`, `result` stays constant until the next reset.
- R11: Raising `rst` in the middle of a run abandons that run, including a call in progress. The next run behaves as if from a clean start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high restart of the whole program |
| op_a | input | W | Dividend operand, captured on the first edge after reset |
| op_b | input | W | First divisor |
| op_c | input | W | Second divisor, used by the remainder call and the last call |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Program result, valid from `done` until the next reset |

## Verification
The assertions assume that `rst` is held high for at least one rising edge before each run. They also assume that the operands are stable at the first edge after `rst` falls. The bench changes operands only while `rst` is high and holds them through the whole run. It also releases reset once in the middle of a call and then re-asserts it, to cover abandoned calls. Inside those assumptions, the properties cover strobe and finish pulse widths, argument stability during iteration, the rule of one outstanding call, and exits from wait states.

// File: rtl/callshare_pkg.sv
package callshare_pkg;

  typedef enum logic [1:0] {
    DV_IDLE,
    DV_INIT,
    DV_STEP,
    DV_DONE
  } div_state_e;

  typedef enum logic [3:0] {
    CP_ENTRY,
    CP_CALL0,
    CP_WAIT0,
    CP_CALL1,
    CP_WAIT1,
    CP_SUM,
    CP_CALL2,
    CP_WAIT2,
    CP_RET,
    CP_HALT
  } prog_state_e;

endpackage

// File: rtl/div_step.sv
module div_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);

  logic [W:0] shifted;
  logic [W:0] trial;
  logic       borrow;

  always_comb begin
    shifted = {rem_i, quo_i[W-1]};
    trial   = shifted - {1'b0, den_i};
    borrow  = trial[W];
    rem_o   = borrow ? shifted[W-1:0] : trial[W-1:0];
    quo_o   = {quo_i[W-2:0], ~borrow};
  end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import callshare_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         call_rst,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  input  logic         mode_i,
  output logic         fin_o,
  output logic [W-1:0] ret_o
);

  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  div_state_e    state;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rem_q, quo_q;
  logic [W-1:0]  rem_n, quo_n;

  div_step #(.W(W)) u_step (
    .rem_i(rem_q),
    .quo_i(quo_q),
    .den_i(den_i),
    .rem_o(rem_n),
    .quo_o(quo_n)
  );

  // next-state process
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DV_IDLE;
    end else if (call_rst) begin
      state <= DV_INIT;
    end else begin
      unique case (state)
        DV_INIT: state <= DV_STEP;
        DV_STEP: if (cnt == '0) state <= DV_DONE;
        DV_DONE: state <= DV_IDLE;
        default: state <= DV_IDLE;
      endcase
    end
  end

  // datapath process
  always_ff @(posedge clk) begin
    if (rst) begin
      fin_o <= 1'b0;
      ret_o <= '0;
      cnt   <= '0;
      rem_q <= '0;
      quo_q <= '0;
    end else if (call_rst) begin
      fin_o <= 1'b0;
    end else begin
      unique case (state)
        DV_INIT: begin
          rem_q <= '0;
          quo_q <= num_i;
          cnt   <= LAST_CNT;
        end
        DV_STEP: begin
          rem_q <= rem_n;
          quo_q <= quo_n;
          cnt   <= cnt - 1'b1;
          if (cnt == '0) begin
            fin_o <= 1'b1;
            ret_o <= mode_i ? rem_n : quo_n;
          end
        end
        DV_DONE: fin_o <= 1'b0;
        default: ;
      endcase
    end
  end

  AST_FIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fin_o |=> (!fin_o && state == DV_IDLE)); // R8
  AST_STROBE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    call_rst |=> (state == DV_INIT && !fin_o)); // R6
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    (state != DV_IDLE) |-> !call_rst); // R7
  AST_ARGS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (state == DV_STEP && $past(state) == DV_STEP) |-> ($stable(den_i) && $stable(mode_i))); // R6

endmodule

// File: rtl/call_program.sv
module call_program
  import callshare_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic         fin_i,
  input  logic [W-1:0] ret_i,
  output logic         call_o,
  output logic [W-1:0] num_o,
  output logic [W-1:0] den_o,
  output logic         mode_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);

  prog_state_e  state;
  logic [W-1:0] a_q, b_q, c_q;
  logic [W-1:0] t0_q, t1_q, t2_q, sum_q;
  logic         in_wait;

  assign in_wait = (state == CP_WAIT0) || (state == CP_WAIT1) || (state == CP_WAIT2);

  // next-state process
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CP_ENTRY;
    end else begin
      unique case (state)
        CP_ENTRY: state <= CP_CALL0;
        CP_CALL0: state <= CP_WAIT0;
        CP_WAIT0: if (fin_i) state <= CP_CALL1;
        CP_CALL1: state <= CP_WAIT1;
        CP_WAIT1: if (fin_i) state <= CP_SUM;
        CP_SUM:   state <= CP_CALL2;
        CP_CALL2: state <= CP_WAIT2;
        CP_WAIT2: if (fin_i) state <= CP_RET;
        CP_RET:   state <= CP_HALT;
        default:  state <= CP_HALT;
      endcase
    end
  end

  // datapath process
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q      <= '0;
      b_q      <= '0;
      c_q      <= '0;
      t0_q     <= '0;
      t1_q     <= '0;
      t2_q     <= '0;
      sum_q    <= '0;
      call_o   <= 1'b0;
      num_o    <= '0;
      den_o    <= '0;
      mode_o   <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      call_o <= 1'b0;
      unique case (state)
        CP_ENTRY: begin
          a_q <= op_a;
          b_q <= op_b;
          c_q <= op_c;
        end
        CP_CALL0: begin
          num_o  <= a_q;
          den_o  <= b_q;
          mode_o <= 1'b0;
          call_o <= 1'b1;
        end
        CP_WAIT0: t0_q <= ret_i;
        CP_CALL1: begin
          num_o  <= a_q;
          den_o  <= c_q;
          mode_o <= 1'b1;
          call_o <= 1'b1;
        end
        CP_WAIT1: t1_q <= ret_i;
        CP_SUM:   sum_q <= t0_q + t1_q;
        CP_CALL2: begin
          num_o  <= sum_q;
          den_o  <= c_q;
          mode_o <= 1'b0;
          call_o <= 1'b1;
        end
        CP_WAIT2: t2_q <= ret_i;
        CP_RET: begin
          done_o   <= 1'b1;
          result_o <= t2_q + t0_q;
        end
        default: done_o <= 1'b0;
      endcase
    end
  end

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    call_o |=> !call_o); // R6
  AST_WAIT_EXIT_ON_FIN: assert property (@(posedge clk) disable iff (rst)
    ($past(in_wait) && state != $past(state)) |-> $past(fin_i)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == CP_HALT && $past(state) == CP_HALT) |-> $stable(result_o)); // R10

endmodule

// File: rtl/callshare_top.sv
module callshare_top #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] op_c,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  logic              call_strobe;
  logic              div_fin;
  logic              div_mode;
  logic [DATA_W-1:0] div_num, div_den, div_ret;

  call_program #(.W(DATA_W)) u_prog (
    .clk     (clk),
    .rst     (rst),
    .op_a    (op_a),
    .op_b    (op_b),
    .op_c    (op_c),
    .fin_i   (div_fin),
    .ret_i   (div_ret),
    .call_o  (call_strobe),
    .num_o   (div_num),
    .den_o   (div_den),
    .mode_o  (div_mode),
    .done_o  (done),
    .result_o(result)
  );

  seq_divider #(.W(DATA_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .call_rst(call_strobe),
    .num_i   (div_num),
    .den_i   (div_den),
    .mode_i  (div_mode),
    .fin_o   (div_fin),
    .ret_o   (div_ret)
  );

  AST_NO_DONE_IN_CALL: assert property (@(posedge clk) disable iff (rst)
    call_strobe |-> !done); // R1

endmodule

// File: tb/callshare_top_tb.sv
module callshare_top_tb;

  localparam int W   = 32;
  localparam int EXP = 3 * W + 15;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
  logic         done;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  callshare_top #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .done(done), .result(result)
  );

  function automatic logic [W-1:0] m_div(logic [W-1:0] n, logic [W-1:0] d);
    return (d == '0) ? '1 : n / d;
  endfunction

  function automatic logic [W-1:0] m_mod(logic [W-1:0] n, logic [W-1:0] d);
    return (d == '0) ? n : n % d;
  endfunction

  function automatic logic [W-1:0] m_prog(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    logic [W-1:0] q0;
    q0 = m_div(a, b);
    return m_div(q0 + m_mod(a, c), c) + q0;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp_v);
    end
  endtask

  // result check also exercises R6 R7 R8 R9 through the call chain
  task automatic run_case(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] c, input string tag);
    int first_hi;
    int n_hi;
    logic [W-1:0] got;
    logic [W-1:0] held;
    @(negedge clk);
    rst  = 1'b1;
    op_a = a; op_b = b; op_c = c;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R1", "done during reset", W'(done), '0);
    rst = 1'b0;
    first_hi = -1;
    n_hi = 0;
    got = '0;
    for (int n = 1; n <= EXP + 4; n++) begin
      @(negedge clk);
      if (done) begin
        n_hi++;
        if (first_hi < 0) begin
          first_hi = n;
          got = result;
        end
      end
    end
    check(first_hi == EXP && n_hi == 1, "R5", "done edge/width",
          W'(first_hi * 16 + n_hi), W'(EXP * 16 + 1));
    check(got == m_prog(a, b, c), tag, "result", got, m_prog(a, b, c));
    held = result;
    repeat (5) @(negedge clk);
    check(result == held && !done, "R10", "result hold", result, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rb, rc;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "reset state", W'(done), '0);

    run_case(32'd100, 32'd7, 32'd9, "R2");
    run_case(32'd1000, 32'd3, 32'd7, "R3");
    run_case(32'd37, 32'd0, 32'd5, "R4");
    run_case(32'd37, 32'd6, 32'd0, "R4");
    run_case(32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFF, "R2");
    run_case(32'd5, 32'd9, 32'd11, "R3");

    // abandon a run in the middle of its first call, then rerun
    @(negedge clk);
    rst = 1'b1; op_a = 32'd999; op_b = 32'd4; op_c = 32'd13;
    @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    run_case(32'd12345, 32'd17, 32'd23, "R11");

    for (int i = 0; i < 18; i++) begin
      ra = $urandom;
      rb = (i % 3 == 0) ? ($urandom % 64) : $urandom;
      rc = (i % 2 == 0) ? ($urandom % 1000) : ($urandom >> (i % 20));
      run_case(ra, rb, rc, "R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule